// File: doc/BRIEF.md
# Serial Receiver with Break and Framing Recovery

This block turns an asynchronous serial line into characters. It runs from the system clock and uses a one-cycle enable pulse, `tick16`, that occurs sixteen times per bit period. The receiver finds the falling edge of a start bit and confirms it half a bit later. It then takes each data bit, the optional parity bit and one stop bit at the middle of the bit. Each finished character comes out on `char_data`, together with a one-cycle `char_valid` strobe and three status flags.

Two line conditions get special handling. If a character with non-zero content has a low stop bit and the line is still low half a bit after that, the receiver treats that moment as the start edge of the next character. If the line stays low for a whole character, the receiver delivers an all-zero break character. It then waits for half a bit of continuous high level before it looks for a new start edge. The data length and parity mode are static settings. The block has no storage queue and no host interface.

Top module: `uart_brk_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `char_valid`, `char_data`, `err_parity`, `err_frame` and `rx_break` are all zero until the first character completes.
- R2: A falling edge on `rx_line` is accepted as a start bit only if the line is still low at the 8th `tick16` after the edge. A shorter low pulse produces no character.
- R3: Bits are taken every 16 ticks at the bit centre, least significant bit first. A completed character raises `char_valid` for exactly one clock, with the byte on `char_data`.
- R4: `cfg_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits of `char_data` above the selected length read zero.
- R5: `cfg_parity` selects the parity mode: 0 means no parity bit, 1 means even, 2 means odd, and 3 means the parity bit must be 1. `err_parity` is set when the received parity bit disagrees with the mode. It is never set when the mode is 0.
- R6: A low stop-bit sample sets `err_frame`, and the assembled data is still delivered.
- R7: After a character with non-zero content and a low stop bit, if the line is low 8 ticks after the stop sample, that point counts as a start edge. The following character is received without a fresh high-to-low edge.
- R8: If the data bits, the parity bit and the stop bit are all low, the character is delivered as 0x00 with `rx_break`=1, `err_frame`=1 and `err_parity`=0.
- R9: After a break, the search for a start edge resumes only after 8 consecutive ticks with the line high. A shorter high pulse followed by a low level produces no character.
- R10: After a good stop bit the receiver searches again at once, so characters with a single stop bit placed back to back are all received.
- R11: While `enable` is low, the receiver returns to its idle search and a partly received character is dropped without a strobe.
- R12: `char_data` and the three flags change only in the cycle `char_valid` is high, and they hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| enable | input | 1 | Receiver run control; low forces idle |
| rx_line | input | 1 | Serial input, idle high |
| cfg_len | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_parity | input | 2 | Parity mode code |
| char_valid | output | 1 | One-cycle character-ready strobe |
| char_data | output | 8 | Received character, zero-extended |
| err_parity | output | 1 | Parity mismatch on the last character |
| err_frame | output | 1 | Low stop bit on the last character |
| rx_break | output | 1 | Last character was a line break |

## Verification
The assertions check on every cycle the properties that hold at all times:
- the strobe lasts a single cycle;
- the outputs stay stable between strobes;
- unused high bits stay zero;
- a break always carries zero data and the frame flag;
- a failed start check returns the receiver to idle;
- a disabled receiver stays idle;
- a low line keeps the break wait from ending.

Only the directed scenarios can show that the correct byte is assembled and that a framing error runs straight into the next character. The same holds for the rejection of short glitches before a start and after a break, and for the loss of a character when `enable` drops mid-frame. Each of these is a timed sequence on the line, and its outcome is visible only in the count and content of the characters delivered.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  localparam int CHAR_W   = 8;
  localparam int MIN_BITS = 5;
  localparam int LEN_W    = 2;
  localparam int IDX_W    = $clog2(CHAR_W + 1);

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_MARK = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PARITY,
    S_STOP,
    S_RESYNC,
    S_BRKWAIT
  } rx_state_e;

  // number of data bits selected by a length code
  function automatic int char_bits(input logic [LEN_W-1:0] code);
    return MIN_BITS + int'(code);
  endfunction

  // shift register fills from the top; move the character down to bit 0
  function automatic logic [CHAR_W-1:0] align_char(input logic [CHAR_W-1:0] sh,
                                                   input logic [LEN_W-1:0] code);
    return sh >> (CHAR_W - char_bits(code));
  endfunction

  function automatic logic parity_bad(input logic [CHAR_W-1:0] d,
                                      input logic pbit,
                                      input par_mode_e mode);
    case (mode)
      PAR_EVEN: return (^d) ^ pbit;
      PAR_ODD:  return ~((^d) ^ pbit);
      PAR_MARK: return ~pbit;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic upper_clear(input logic [CHAR_W-1:0] d,
                                       input logic [LEN_W-1:0] code);
    return (d >> char_bits(code)) == '0;
  endfunction
endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IDLE_LVL;
        else        q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= {STAGES{IDLE_LVL}};
        else        q <= {q[STAGES-2:0], din};
      end
      assign dout = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/serrx_bitclk.sv
module serrx_bitclk #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic mid_hit,
  output logic full_hit
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int HALF  = OVERSAMPLE / 2;

  logic [CNT_W-1:0] cnt;

  assign mid_hit  = tick && (cnt == CNT_W'(HALF - 1));
  assign full_hit = tick && (cnt == CNT_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (tick)   cnt <= full_hit ? '0 : cnt + 1'b1;
  end

  // R3: a bit-period boundary always restarts the phase count
  assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_hit |=> (cnt == '0));
endmodule

// File: rtl/serrx_asm.sv
module serrx_asm
  import serrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              cap_par,
  input  logic              bit_in,
  input  logic [LEN_W-1:0]  len_code,
  output logic [CHAR_W-1:0] data_out,
  output logic              last_bit,
  output logic              par_bit,
  output logic              all_low
);
  logic [CHAR_W-1:0] sh;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      idx     <= '0;
      par_bit <= 1'b0;
    end else if (clear) begin
      sh      <= '0;
      idx     <= '0;
      par_bit <= 1'b0;
    end else begin
      if (shift_en) begin
        sh  <= {bit_in, sh[CHAR_W-1:1]};
        idx <= idx + 1'b1;
      end
      if (cap_par) par_bit <= bit_in;
    end
  end

  assign last_bit = (idx == IDX_W'(char_bits(len_code) - 1));
  assign data_out = align_char(sh, len_code);
  assign all_low  = (sh == '0) && !par_bit;

  // R4: the controller never shifts past the configured length
  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (idx < IDX_W'(char_bits(len_code))));
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import serrx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              enable,
  input  logic              rx_line,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [1:0]        cfg_parity,
  output logic              char_valid,
  output logic [CHAR_W-1:0] char_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              rx_break
);
  rx_state_e         state, state_d;
  par_mode_e         par_mode;
  logic              par_en;
  logic              line_s, line_q;
  logic              clk_clear, asm_clear, shift_en, cap_par, emit;
  logic              mid_hit, full_hit;
  logic [CHAR_W-1:0] asm_data;
  logic              last_bit, par_bit, all_low;

  // named internal events
  logic start_edge, false_start, brk_seen, resync_go;

  assign par_mode = par_mode_e'(cfg_parity);
  assign par_en   = (par_mode != PAR_NONE);

  serrx_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_line),
    .dout  (line_s)
  );

  serrx_bitclk #(.OVERSAMPLE(OVERSAMPLE)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .clear    (clk_clear),
    .mid_hit  (mid_hit),
    .full_hit (full_hit)
  );

  serrx_asm u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (asm_clear),
    .shift_en (shift_en),
    .cap_par  (cap_par),
    .bit_in   (line_s),
    .len_code (cfg_len),
    .data_out (asm_data),
    .last_bit (last_bit),
    .par_bit  (par_bit),
    .all_low  (all_low)
  );

  // line level seen at the previous tick, for edge search
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      line_q <= 1'b1;
    else if (tick16) line_q <= line_s;
  end

  assign start_edge  = tick16 && line_q && !line_s;
  assign false_start = (state == S_START) && mid_hit && line_s;
  assign brk_seen    = (state == S_STOP) && full_hit && !line_s && all_low;
  assign resync_go   = (state == S_RESYNC) && mid_hit && !line_s;

  always_comb begin
    state_d   = state;
    clk_clear = 1'b0;
    asm_clear = 1'b0;
    shift_en  = 1'b0;
    cap_par   = 1'b0;
    emit      = 1'b0;
    if (!enable) begin
      state_d   = S_IDLE;
      clk_clear = 1'b1;
      asm_clear = 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          clk_clear = 1'b1;
          if (start_edge) begin
            state_d   = S_START;
            asm_clear = 1'b1;
          end
        end
        S_START: begin
          if (mid_hit) begin
            clk_clear = 1'b1;
            state_d   = line_s ? S_IDLE : S_DATA;
          end
        end
        S_DATA: begin
          if (full_hit) begin
            shift_en = 1'b1;
            if (last_bit) state_d = par_en ? S_PARITY : S_STOP;
          end
        end
        S_PARITY: begin
          if (full_hit) begin
            cap_par = 1'b1;
            state_d = S_STOP;
          end
        end
        S_STOP: begin
          if (full_hit) begin
            emit      = 1'b1;
            clk_clear = 1'b1;
            if (line_s)              state_d = S_IDLE;
            else if (all_low)        state_d = S_BRKWAIT;
            else if (asm_data != '0) state_d = S_RESYNC;
            else                     state_d = S_IDLE;
          end
        end
        S_RESYNC: begin
          if (mid_hit) begin
            clk_clear = 1'b1;
            if (resync_go) begin
              state_d   = S_START;
              asm_clear = 1'b1;
            end else begin
              state_d   = S_IDLE;
            end
          end
        end
        S_BRKWAIT: begin
          clk_clear = !line_s;
          if (mid_hit && line_s) state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_valid <= 1'b0;
      char_data  <= '0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
      rx_break   <= 1'b0;
    end else begin
      char_valid <= emit;
      if (emit) begin
        char_data  <= asm_data;
        err_frame  <= !line_s;
        rx_break   <= brk_seen;
        err_parity <= par_en && !brk_seen && parity_bad(asm_data, par_bit, par_mode);
      end
    end
  end

  // R3: character strobe is a single-cycle pulse
  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);

  // R4: bits above the configured length are zero
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> upper_clear(char_data, cfg_len));

  // R5: no parity error without a parity bit
  assert_noparity_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && cfg_parity == 2'd0) |-> !err_parity);

  // R8: a break character is zero with the frame flag and no parity flag
  assert_break_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && rx_break) |-> (char_data == '0 && err_frame && !err_parity));

  // R2: a high sample at the start check returns to the search
  assert_false_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (false_start && enable) |=> (state == S_IDLE));

  // R9: low line keeps the break wait going
  assert_brkwait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BRKWAIT && !line_s && enable) |=> (state == S_BRKWAIT));

  // R11: a disabled receiver sits idle and emits nothing
  assert_disable_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == S_IDLE && !char_valid));

  // R12: results move only with the strobe
  assert_hold_between_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !char_valid |-> $stable({char_data, err_parity, err_frame, rx_break}));
endmodule

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb;
  localparam int BIT_CLKS = 48;  // tick every 3 clocks, 16 ticks per bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       enable = 1'b1;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_parity = 2'd0;
  logic       char_valid;
  logic [7:0] char_data;
  logic       err_parity, err_frame, rx_break;

  int n_checks = 0;
  int n_errs   = 0;
  int rx_cnt   = 0;
  logic [10:0] cap_last = '0;
  logic [10:0] cap_prev = '0;

  always #2.5 clk = ~clk;

  uart_brk_rx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .enable     (enable),
    .rx_line    (rx_line),
    .cfg_len    (cfg_len),
    .cfg_parity (cfg_parity),
    .char_valid (char_valid),
    .char_data  (char_data),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .rx_break   (rx_break)
  );

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  // record every delivered character as {break, frame, parity, data}
  always @(negedge clk) begin
    if (rst_n && char_valid) begin
      cap_prev = cap_last;
      cap_last = {rx_break, err_frame, err_parity, char_data};
      rx_cnt   = rx_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic b, input int clks);
    rx_line = b;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nbits,
                            input bit use_par, input logic pbit, input logic stopv);
    @(negedge clk);
    drive(1'b0, BIT_CLKS);
    for (int i = 0; i < nbits; i++) drive(d[i], BIT_CLKS);
    if (use_par) drive(pbit, BIT_CLKS);
    drive(stopv, BIT_CLKS);
    rx_line = 1'b1;
  endtask

  task automatic idle_bits(input int n);
    rx_line = 1'b1;
    repeat (n * BIT_CLKS) @(posedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", 32'({char_valid, char_data, err_parity, err_frame, rx_break}), 32'd0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 outputs after reset", 32'({char_valid, char_data, err_parity, err_frame, rx_break}), 32'd0);
    chk("R1 no character", 32'(rx_cnt), 32'd0);
  endtask

  task automatic t_basic;
    int c0;
    cfg_len = 2'd3; cfg_parity = 2'd0;
    c0 = rx_cnt;
    send_frame(8'hA5, 8, 0, 1'b0, 1'b1);
    idle_bits(2);
    chk("R3 count A5", 32'(rx_cnt - c0), 32'd1);
    chk("R3 data A5", 32'(cap_last), 32'h0A5);
    send_frame(8'h3C, 8, 0, 1'b0, 1'b1);
    idle_bits(2);
    chk("R3 data 3C", 32'(cap_last), 32'h03C);
  endtask

  task automatic t_length;
    cfg_len = 2'd0; cfg_parity = 2'd0;
    send_frame(8'hFF, 5, 0, 1'b0, 1'b1);
    idle_bits(2);
    chk("R4 five bits", 32'(cap_last), 32'h01F);
    cfg_len = 2'd2;
    send_frame(8'hD5, 7, 0, 1'b0, 1'b1);
    idle_bits(2);
    chk("R4 seven bits", 32'(cap_last), 32'h055);
    cfg_len = 2'd3;
  endtask

  task automatic t_parity;
    logic [7:0] d;
    d = 8'h96;
    cfg_parity = 2'd1;
    send_frame(d, 8, 1, ^d, 1'b1);
    idle_bits(2);
    chk("R5 even good", 32'(cap_last), 32'h096);
    send_frame(d, 8, 1, ~(^d), 1'b1);
    idle_bits(2);
    chk("R5 even bad", 32'(cap_last), 32'h196);
    chk("R12 flag held", 32'(err_parity), 32'd1);
    cfg_parity = 2'd2;
    send_frame(d, 8, 1, ~(^d), 1'b1);
    idle_bits(2);
    chk("R12 flag cleared by next strobe R5 odd good", 32'(cap_last), 32'h096);
    cfg_parity = 2'd3;
    send_frame(8'h01, 8, 1, 1'b0, 1'b1);
    idle_bits(2);
    chk("R5 mark bad", 32'(cap_last), 32'h101);
    send_frame(8'h01, 8, 1, 1'b1, 1'b1);
    idle_bits(2);
    chk("R5 mark good", 32'(cap_last), 32'h001);
    cfg_parity = 2'd0;
  endtask

  task automatic t_frame;
    int c0;
    c0 = rx_cnt;
    @(negedge clk);
    drive(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) drive(i[0] ? 1'b0 : 1'b1, BIT_CLKS);
    drive(1'b0, (BIT_CLKS * 3) / 4);
    idle_bits(3);
    chk("R6 one char", 32'(rx_cnt - c0), 32'd1);
    chk("R6 frame error", 32'(cap_last), 32'h255);
  endtask

  task automatic t_resync;
    int c0;
    c0 = rx_cnt;
    send_frame(8'h5A, 8, 0, 1'b0, 1'b0);
    send_frame(8'h96, 8, 0, 1'b0, 1'b1);
    idle_bits(2);
    chk("R7 two chars", 32'(rx_cnt - c0), 32'd2);
    chk("R7 first framed", 32'(cap_prev), 32'h25A);
    chk("R7 second clean", 32'(cap_last), 32'h096);
  endtask

  task automatic t_break;
    int c0;
    c0 = rx_cnt;
    @(negedge clk);
    drive(1'b0, 12 * BIT_CLKS);
    chk("R8 break count", 32'(rx_cnt - c0), 32'd1);
    chk("R8 break char", 32'(cap_last), 32'h600);
    drive(1'b1, 12);
    drive(1'b0, 2 * BIT_CLKS);
    idle_bits(3);
    chk("R9 glitch ignored", 32'(rx_cnt - c0), 32'd1);
    send_frame(8'h81, 8, 0, 1'b0, 1'b1);
    idle_bits(2);
    chk("R9 recovers", 32'(cap_last), 32'h081);
  endtask

  task automatic t_false_start;
    int c0;
    c0 = rx_cnt;
    @(negedge clk);
    drive(1'b0, 12);
    idle_bits(3);
    @(negedge clk);
    drive(1'b0, 18);
    idle_bits(3);
    chk("R2 short lows rejected", 32'(rx_cnt - c0), 32'd0);
  endtask

  task automatic t_disable;
    int c0;
    logic [7:0] d;
    d = 8'hF0;
    c0 = rx_cnt;
    @(negedge clk);
    drive(1'b0, BIT_CLKS);
    for (int i = 0; i < 3; i++) drive(d[i], BIT_CLKS);
    enable = 1'b0;
    for (int i = 3; i < 8; i++) drive(d[i], BIT_CLKS);
    drive(1'b1, BIT_CLKS);
    enable = 1'b1;
    idle_bits(2);
    chk("R11 partial dropped", 32'(rx_cnt - c0), 32'd0);
    send_frame(8'hC3, 8, 0, 1'b0, 1'b1);
    idle_bits(2);
    chk("R11 works after enable", 32'(cap_last), 32'h0C3);
  endtask

  task automatic t_back2back;
    int c0;
    c0 = rx_cnt;
    send_frame(8'h0F, 8, 0, 1'b0, 1'b1);
    send_frame(8'hF0, 8, 0, 1'b0, 1'b1);
    idle_bits(2);
    chk("R10 two chars", 32'(rx_cnt - c0), 32'd2);
    chk("R10 first", 32'(cap_prev), 32'h00F);
    chk("R10 second", 32'(cap_last), 32'h0F0);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    t_reset();
    idle_bits(2);
    t_basic();
    t_length();
    t_parity();
    t_frame();
    t_resync();
    t_break();
    t_false_start();
    t_disable();
    t_back2back();
    summary();
  end
endmodule